// File: doc/BRIEF.md
# ADC Wake-and-Convert Sequencer

This block drives the single control line of a sampling converter. That line does two jobs. A rising edge wakes the converter from its low-power state, and a falling edge starts a conversion. In every sample period the sequencer raises the line, lowers it, and then waits the worst-case conversion time. It then emits a one-cycle sample strobe and leaves the line low until the next period starts. Between samples the converter therefore sits powered down.

The wake-up delay depends on which reference the converter uses. With the on-chip reference the line is held high for the full wake-up time, and the falling edge itself starts the conversion. With an external reference the high pulse is short. The conversion then begins only when the external wake-up time has run out, so the sequencer counts the remaining wake time before it counts the conversion. Every duration is given in nanoseconds and converted to clock cycles using the clock frequency, rounded up. The reference choice and the sample period are taken at the start of each cycle.

Top module: `adc_pwr_seq`

## Requirements
- R1: While reset is high, and after its release until enable is seen high, `conv_line`, `busy` and `sample_stb` are all 0, whatever the other inputs do.
- R2: From idle, the clock edge that first samples `en` = 1 starts a cycle. `conv_line` is 1 in the cycle that follows that edge, which is cycle position 0.
- R3: With `ref_onchip` = 0, `conv_line` is high for ceil(PULSE_EXT_NS·CLK_MHZ/1000) cycles. `busy` then stays high, with the line low, for the rest of ceil(WAKE_EXT_NS·CLK_MHZ/1000) cycles counted from position 0, before the conversion window begins.
- R4: With `ref_onchip` = 1, `conv_line` is high for exactly ceil(WAKE_INT_NS·CLK_MHZ/1000) cycles, and the conversion window begins as soon as the line falls.
- R5: The conversion window lasts ceil(CONV_NS·CLK_MHZ/1000) cycles. During it `busy` = 1 and `conv_line` = 0.
- R6: `sample_stb` is 1 for exactly one cycle, at position A−1, where A is the high time plus the remaining wake time plus the conversion time plus 1. In that cycle `busy` is 0.
- R7: The next cycle starts at position max(P, A), where P is the `period` value taken at the start of the current cycle (0 means as fast as possible). Between the strobe and that point all outputs are 0.
- R8: If `en` drops while a cycle is active, the cycle runs to its strobe and no new cycle starts. If `en` drops while the sequencer sleeps, no new cycle starts. Re-enabling from idle behaves as in R2.
- R9: A change of `ref_onchip` or `period` in the middle of a cycle has no effect until the next cycle starts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Run enable |
| ref_onchip | input | 1 | 1: on-chip reference, 0: external reference |
| period | input | PER_W | Sample period in clock cycles |
| conv_line | output | 1 | Wake/start control line to the converter |
| busy | output | 1 | High while waking or converting |
| sample_stb | output | 1 | One-cycle pulse when the result is ready |

## Verification
The bench sweeps both reference modes over periods below, at, just above and well above the active length A. A design that ignored the floor would start the next wake before the strobe, and an off-by-one in the wrap would shift every later edge by a cycle. The external-reference case checks that the conversion count starts at the end of the wake time and not at the falling edge; a design that got this wrong would strobe 14 cycles early. Mid-cycle changes to the reference and period, and a disable in the middle of a conversion, are checked against a per-cycle model. A design that applied the change at once, or abandoned the conversion, would alter the line or lose the strobe.

// File: rtl/adcseq_pkg.sv
package adcseq_pkg;

    typedef enum logic [2:0] {
        SQ_IDLE  = 3'd0,
        SQ_WAKE  = 3'd1,
        SQ_START = 3'd2,
        SQ_CONV  = 3'd3,
        SQ_DONE  = 3'd4,
        SQ_SLEEP = 3'd5
    } seq_state_e;

    typedef struct packed {
        logic line;
        logic busy;
        logic strobe;
    } ctl_out_t;

    // Nanoseconds to clock cycles, rounded up.
    function automatic int unsigned ns_to_cyc(input int unsigned ns, input int unsigned mhz);
        return (ns * mhz + 999) / 1000;
    endfunction

    function automatic int unsigned umax(input int unsigned a, input int unsigned b);
        return (a > b) ? a : b;
    endfunction

    function automatic int unsigned umin(input int unsigned a, input int unsigned b);
        return (a < b) ? a : b;
    endfunction

    function automatic logic is_active(input seq_state_e s);
        return (s == SQ_WAKE) || (s == SQ_START) || (s == SQ_CONV);
    endfunction

endpackage

// File: rtl/adcseq_timing.sv
module adcseq_timing
    import adcseq_pkg::*;
#(
    parameter int unsigned CNT_W  = 16,
    parameter int unsigned HI_EXT = 2,
    parameter int unsigned ST_EXT = 2,
    parameter int unsigned HI_INT = 8,
    parameter int unsigned CONV   = 2
) (
    input  logic             ref_int,
    output logic [CNT_W-1:0] hi_end,
    output logic [CNT_W-1:0] st_end,
    output logic [CNT_W-1:0] cv_end,
    output logic             has_start
);
    // Last elapsed-count value of each phase, one set per reference variant.
    localparam int unsigned E_HI_END = HI_EXT - 1;
    localparam int unsigned E_ST_END = HI_EXT + ST_EXT - 1;
    localparam int unsigned E_CV_END = HI_EXT + ST_EXT + CONV - 1;
    localparam int unsigned I_HI_END = HI_INT - 1;
    localparam int unsigned I_CV_END = HI_INT + CONV - 1;

    generate
        if (ST_EXT == 0) begin : g_no_ext_start
            assign has_start = 1'b0;
        end else begin : g_ext_start
            assign has_start = !ref_int;
        end
    endgenerate

    always_comb begin
        if (ref_int) begin
            hi_end = CNT_W'(I_HI_END);
            st_end = CNT_W'(I_HI_END);
            cv_end = CNT_W'(I_CV_END);
        end else begin
            hi_end = CNT_W'(E_HI_END);
            st_end = CNT_W'(E_ST_END);
            cv_end = CNT_W'(E_CV_END);
        end
    end

endmodule

// File: rtl/adcseq_fsm.sv
module adcseq_fsm
    import adcseq_pkg::*;
#(
    parameter int unsigned CNT_W = 16,
    parameter int unsigned PER_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             en,
    input  logic             ref_in,
    input  logic [PER_W-1:0] per_in,
    input  logic [CNT_W-1:0] hi_end,
    input  logic [CNT_W-1:0] st_end,
    input  logic [CNT_W-1:0] cv_end,
    input  logic             has_start,
    output seq_state_e       state_n,
    output logic             ref_q
);
    seq_state_e       state;
    logic [CNT_W-1:0] elapsed;
    logic [PER_W-1:0] per_q;
    logic [CNT_W:0]   elapsed_p1;
    logic             per_reached;
    logic             new_cycle;

    assign elapsed_p1  = {1'b0, elapsed} + 1'b1;
    assign per_reached = elapsed_p1 >= (CNT_W + 1)'(per_q);
    assign new_cycle   = (state_n == SQ_WAKE) && (state != SQ_WAKE);

    always_comb begin
        state_n = state;
        unique case (state)
            SQ_IDLE: begin
                if (en) state_n = SQ_WAKE;
            end
            SQ_WAKE: begin
                if (elapsed == hi_end) state_n = has_start ? SQ_START : SQ_CONV;
            end
            SQ_START: begin
                if (elapsed == st_end) state_n = SQ_CONV;
            end
            SQ_CONV: begin
                if (elapsed == cv_end) state_n = SQ_DONE;
            end
            SQ_DONE, SQ_SLEEP: begin
                if (!en)              state_n = SQ_IDLE;
                else if (per_reached) state_n = SQ_WAKE;
                else                  state_n = SQ_SLEEP;
            end
            default: state_n = SQ_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= SQ_IDLE;
            elapsed <= '0;
            per_q   <= '0;
            ref_q   <= 1'b0;
        end else begin
            state <= state_n;
            if (new_cycle) begin
                elapsed <= '0;
                per_q   <= per_in;
                ref_q   <= ref_in;
            end else if (state_n == SQ_IDLE) begin
                elapsed <= '0;
            end else begin
                elapsed <= elapsed_p1[CNT_W-1:0];
            end
        end
    end

endmodule

// File: rtl/adcseq_outreg.sv
module adcseq_outreg
    import adcseq_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  seq_state_e state_n,
    output ctl_out_t   ctl
);
    ctl_out_t ctl_n;

    always_comb begin
        ctl_n.line   = (state_n == SQ_WAKE);
        ctl_n.busy   = is_active(state_n);
        ctl_n.strobe = (state_n == SQ_DONE);
    end

    // Every output leaves a flop, so the control line cannot glitch.
    always_ff @(posedge clk) begin
        if (rst) ctl <= '0;
        else     ctl <= ctl_n;
    end

endmodule

// File: rtl/adc_pwr_seq.sv
module adc_pwr_seq
    import adcseq_pkg::*;
#(
    parameter int unsigned CLK_MHZ      = 250,
    parameter int unsigned WAKE_EXT_NS  = 1000,
    parameter int unsigned WAKE_INT_NS  = 25000,
    parameter int unsigned PULSE_EXT_NS = 300,
    parameter int unsigned CONV_NS      = 420,
    parameter int unsigned PER_W        = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             en,
    input  logic             ref_onchip,
    input  logic [PER_W-1:0] period,
    output logic             conv_line,
    output logic             busy,
    output logic             sample_stb
);
    localparam int unsigned WAKE_EXT_C = umax(ns_to_cyc(WAKE_EXT_NS, CLK_MHZ), 1);
    localparam int unsigned HI_EXT_C   = umin(umax(ns_to_cyc(PULSE_EXT_NS, CLK_MHZ), 1), WAKE_EXT_C);
    localparam int unsigned ST_EXT_C   = WAKE_EXT_C - HI_EXT_C;
    localparam int unsigned HI_INT_C   = umax(ns_to_cyc(WAKE_INT_NS, CLK_MHZ), 1);
    localparam int unsigned CONV_C     = umax(ns_to_cyc(CONV_NS, CLK_MHZ), 1);
    localparam int unsigned ACT_MAX    = umax(WAKE_EXT_C, HI_INT_C) + CONV_C + 1;
    localparam int unsigned CNT_W      = umax(PER_W, $clog2(ACT_MAX + 1));

    logic [CNT_W-1:0] hi_end, st_end, cv_end;
    logic             has_start;
    logic             ref_q;
    seq_state_e       state_n;
    ctl_out_t         ctl;

    adcseq_timing #(
        .CNT_W (CNT_W),
        .HI_EXT(HI_EXT_C),
        .ST_EXT(ST_EXT_C),
        .HI_INT(HI_INT_C),
        .CONV  (CONV_C)
    ) u_timing (
        .ref_int  (ref_q),
        .hi_end   (hi_end),
        .st_end   (st_end),
        .cv_end   (cv_end),
        .has_start(has_start)
    );

    adcseq_fsm #(
        .CNT_W(CNT_W),
        .PER_W(PER_W)
    ) u_fsm (
        .clk      (clk),
        .rst      (rst),
        .en       (en),
        .ref_in   (ref_onchip),
        .per_in   (period),
        .hi_end   (hi_end),
        .st_end   (st_end),
        .cv_end   (cv_end),
        .has_start(has_start),
        .state_n  (state_n),
        .ref_q    (ref_q)
    );

    adcseq_outreg u_out (
        .clk    (clk),
        .rst    (rst),
        .state_n(state_n),
        .ctl    (ctl)
    );

    assign conv_line  = ctl.line;
    assign busy       = ctl.busy;
    assign sample_stb = ctl.strobe;

endmodule

// File: rtl/adcseq_chk.sv
module adcseq_chk #(
    parameter int unsigned CLK_MHZ     = 250,
    parameter int unsigned WAKE_INT_NS = 25000,
    parameter int unsigned CONV_NS     = 420
) (
    input logic clk,
    input logic rst,
    input logic conv_line,
    input logic busy,
    input logic sample_stb,
    input logic ref_q
);
    localparam int unsigned HI_INT_C = (WAKE_INT_NS * CLK_MHZ + 999) / 1000;
    localparam int unsigned CONV_C   = (CONV_NS * CLK_MHZ + 999) / 1000;

    int unsigned hi_run;
    int unsigned low_busy_run;

    always_ff @(posedge clk) begin
        if (rst) begin
            hi_run       <= 0;
            low_busy_run <= 0;
        end else begin
            hi_run       <= conv_line ? hi_run + 1 : 0;
            low_busy_run <= (busy && !conv_line) ? low_busy_run + 1 : 0;
        end
    end

    p_quiet_out_of_reset_r1: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> (!conv_line && !busy && !sample_stb));

    p_line_implies_busy_r2: assert property (@(posedge clk) disable iff (rst)
        conv_line |-> busy);

    p_pulse_cap_r3: assert property (@(posedge clk) disable iff (rst)
        conv_line |-> (hi_run < HI_INT_C));

    p_full_wake_onchip_r4: assert property (@(posedge clk) disable iff (rst)
        ($fell(conv_line) && ref_q) |-> (hi_run == HI_INT_C));

    p_conv_budget_r5: assert property (@(posedge clk) disable iff (rst)
        sample_stb |-> (low_busy_run >= CONV_C));

    p_strobe_single_r6: assert property (@(posedge clk) disable iff (rst)
        sample_stb |=> !sample_stb);

    p_strobe_ends_busy_r6: assert property (@(posedge clk) disable iff (rst)
        sample_stb |-> ($past(busy) && !busy));

endmodule

bind adc_pwr_seq adcseq_chk #(
    .CLK_MHZ    (CLK_MHZ),
    .WAKE_INT_NS(WAKE_INT_NS),
    .CONV_NS    (CONV_NS)
) u_chk (
    .clk       (clk),
    .rst       (rst),
    .conv_line (conv_line),
    .busy      (busy),
    .sample_stb(sample_stb),
    .ref_q     (ref_q)
);

// File: tb/tb_adc_pwr_seq.sv
module tb_adc_pwr_seq;
    localparam int MHZ    = 20;
    localparam int PER_W  = 16;
    // Expected counts from the requirements: ceil(ns * MHZ / 1000)
    localparam int HI_EXT = (300 * MHZ + 999) / 1000;       // 6
    localparam int WK_EXT = (1000 * MHZ + 999) / 1000;      // 20
    localparam int ST_EXT = WK_EXT - HI_EXT;                // 14
    localparam int HI_INT = (25000 * MHZ + 999) / 1000;     // 500
    localparam int CONV   = (420 * MHZ + 999) / 1000;       // 9

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             en = 1'b0;
    logic             ref_in = 1'b0;
    logic [PER_W-1:0] per_in = '0;
    logic             conv_line, busy, sample_stb;

    int nvec = 0;
    int nfail = 0;
    bit finished = 1'b0;

    always #2 clk = ~clk;

    adc_pwr_seq #(
        .CLK_MHZ(MHZ), .WAKE_EXT_NS(1000), .WAKE_INT_NS(25000),
        .PULSE_EXT_NS(300), .CONV_NS(420), .PER_W(PER_W)
    ) dut (
        .clk(clk), .rst(rst), .en(en), .ref_onchip(ref_in), .period(per_in),
        .conv_line(conv_line), .busy(busy), .sample_stb(sample_stb)
    );

    task automatic check(input string req, input logic [2:0] exp);
        logic [2:0] act;
        act = {conv_line, busy, sample_stb};
        nvec++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s t=%0t {line,busy,stb} actual=%b expected=%b", req, $time, act, exp);
        end
    endtask

    // Per-cycle model. Called right after en was raised at a negedge.
    task automatic run_seq(input int ncyc, input int dis_at, input int chg_at,
                           input logic nref, input int nper);
        int pos = 0;
        int hi = 0, st = 0, a = 1, peff = 1;
        bit idle = 1'b0;
        logic [2:0] exp;
        string tag;
        for (int i = 0; i < ncyc; i++) begin
            @(negedge clk);
            if (!idle && pos == 0) begin
                hi   = ref_in ? HI_INT : HI_EXT;
                st   = ref_in ? 0 : ST_EXT;
                a    = hi + st + CONV + 1;
                peff = (int'(per_in) > a) ? int'(per_in) : a;
            end
            if (idle) begin
                exp = 3'b000; tag = "R8";
            end else begin
                exp = {pos < hi, pos < a - 1, pos == a - 1};
                if (pos == 0)            tag = "R2";
                else if (pos < hi)       tag = ref_in ? "R4" : "R3";
                else if (pos < hi + st)  tag = "R3";
                else if (pos < a - 1)    tag = "R5";
                else if (pos == a - 1)   tag = "R6";
                else                     tag = "R7";
                if (i > chg_at && chg_at >= 0) tag = {tag, "/R9"};
            end
            check(tag, exp);
            if (i == dis_at) en = 1'b0;
            if (i == chg_at) begin ref_in = nref; per_in = PER_W'(nper); end
            if (!idle) begin
                pos++;
                if (pos == peff || (!en && pos == a)) begin
                    pos = 0;
                    if (!en) idle = 1'b1;
                end
            end
        end
    endtask

    task automatic start_run(input logic r, input int p);
        @(negedge clk);
        ref_in = r; per_in = PER_W'(p); en = 1'b1;
    endtask

    task automatic sweep(input logic r, input int p, input int nper);
        int hi, a, peff;
        hi   = r ? HI_INT : HI_EXT;
        a    = hi + (r ? 0 : ST_EXT) + CONV + 1;
        peff = (p > a) ? p : a;
        start_run(r, p);
        run_seq(nper * peff + 6, nper * peff - 1, -1, r, p);
    endtask

    initial begin
        // R1: quiet in reset even with enable high, and after release
        en = 1'b1;
        for (int i = 0; i < 5; i++) begin @(negedge clk); check("R1", 3'b000); end
        en = 1'b0;
        @(negedge clk); rst = 1'b0;
        for (int i = 0; i < 5; i++) begin @(negedge clk); check("R1", 3'b000); end

        // R3/R5/R6/R7: external reference, periods around A=30
        sweep(1'b0, 0, 3);
        sweep(1'b0, 1, 3);
        sweep(1'b0, 29, 3);
        sweep(1'b0, 30, 3);
        sweep(1'b0, 31, 3);
        sweep(1'b0, 47, 3);
        // R4/R7: on-chip reference, periods around A=510
        sweep(1'b1, 0, 2);
        sweep(1'b1, 509, 2);
        sweep(1'b1, 511, 2);
        sweep(1'b1, 600, 2);

        // R9: reference and period change mid-cycle take effect next cycle
        start_run(1'b0, 40);
        run_seq(40 + 700 + 6, 40 + 700 - 1, 5, 1'b1, 700);
        start_run(1'b1, 520);
        run_seq(520 + 50 + 6, 520 + 50 - 1, 100, 1'b0, 50);

        // R8: disable during the conversion window, then during sleep
        start_run(1'b0, 100);
        run_seq(150, 24, -1, 1'b0, 100);
        start_run(1'b0, 100);
        run_seq(150, 60, -1, 1'b0, 100);
        // R8: re-enable from idle restarts at once
        start_run(1'b0, 0);
        run_seq(36, 29, -1, 1'b0, 0);

        if (!finished) begin
            finished = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
            $finish;
        end
    end

    initial begin
        #800000;
        if (!finished) begin
            finished = 1'b1;
            nfail++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
            $finish;
        end
    end

endmodule